// File: doc/BRIEF.md
# Sample Formatter with Trigger Timestamp

This block sits between a 12-bit sampling converter core and its output drivers. On every clock it takes one raw sample, in offset-binary form, together with an out-of-range flag. It can recode the word as two's complement, and it hands the result on through a fixed three-cycle pipeline. A strobe marks each output word.

Timestamp mode marks an external event in the data stream. The event arrives on a trigger line that may be asynchronous to the sampling clock. While the mode is on, the least significant bit of every output word is replaced by the captured trigger level. The word then carries 11 data bits and one event bit. The trigger takes exactly the same number of clock edges to reach the output as the sample it is merged with. Downstream logic can therefore tell which sample the event coincided with.

The coding select and the timestamp enable are plain level inputs, normally driven from a control register. They are sampled together with each sample, so a change affects only the samples that enter the pipeline after it. The converter cannot be stalled. For that reason the stream has a valid strobe but no ready signal: the receiver must accept a word on every cycle in which `out_valid` is high, and back-pressure is not possible.

Top module: `sample_formatter`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `out_sample` and `out_oor` are all 0. This holds immediately and does not wait for a clock edge.
- R2: `out_valid` is high exactly three rising edges after the edge at which `in_valid` was sampled high. One input beat gives exactly one output beat.
- R3: With `cfg_twos` = 0 and `cfg_stamp` = 0, `out_sample` equals the input sample unchanged. This is offset-binary coding.
- R4: With `cfg_twos` = 1, bit 11 of the output is the inverse of input bit 11. Bits 10..1 are passed through unchanged.
- R5: With `cfg_stamp` = 1, output bit 0 equals the level of `trig_async` at the same edge that captured the sample. Bits 11..1 follow R3/R4.
- R6: With `cfg_stamp` = 0, `trig_async` has no effect on any output. Bit 0 then equals input bit 0.
- R7: `out_oor` carries the `in_oor` of the same sample, with the same three-edge latency. It is not changed by the coding or timestamp settings.
- R8: `cfg_twos` and `cfg_stamp` are captured per sample. Changing either one between consecutive samples affects only the samples that enter together with the new value.
- R9: While `out_valid` is low, `out_sample` and `out_oor` hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample present this cycle |
| in_sample | input | 12 | Raw offset-binary sample |
| in_oor | input | 1 | Out-of-range flag of the sample |
| cfg_twos | input | 1 | 1 selects two's complement coding |
| cfg_stamp | input | 1 | 1 replaces the LSB with the trigger bit |
| trig_async | input | 1 | External trigger, may be asynchronous |
| out_valid | output | 1 | Output word strobe |
| out_sample | output | 12 | Formatted sample |
| out_oor | output | 1 | Out-of-range flag aligned to `out_sample` |

## Verification
A trigger chain one stage too short or too long does not cause an obvious failure. It shows up as an event bit landing one word early or late beside its sample, three cycles after the event. Only a single-cycle trigger pulse against a steady data pattern exposes it. A data delay line of the wrong length shows up at once as a shifted strobe and as `out_oor` flags that no longer match their samples. A coding setting that is not captured per sample shows up as the wrong MSB on the first word or two after a setting change, so the vectors change the settings between adjacent samples.

// File: rtl/sfmt_pkg.sv
package sfmt_pkg;
  localparam int SMP_W      = 12;
  localparam int PIPE_DEPTH = 3;
  localparam int SYNC_DEPTH = 2;

  typedef enum logic {
    CODE_OFFSET = 1'b0,
    CODE_TWOS   = 1'b1
  } coding_e;
endpackage

// File: rtl/sfmt_coder.sv
module sfmt_coder #(
  parameter int W = 12
) (
  input  logic             coding,
  input  logic [W-1:0]     raw,
  output logic [W-1:0]     coded
);
  import sfmt_pkg::*;

  always_comb begin
    coded = raw;
    if (coding_e'(coding) == CODE_TWOS)
      coded[W-1] = ~raw[W-1];
  end
endmodule

// File: rtl/sfmt_delay.sv
module sfmt_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (DEPTH == 0) begin : g_pass
      assign q = d;
    end else begin : g_regs
      logic [W-1:0] stage [DEPTH];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
        end else begin
          stage[0] <= d;
          for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
        end
      end
      assign q = stage[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/sfmt_trig_sync.sv
module sfmt_trig_sync #(
  parameter int STAGES = 2,
  parameter int ALIGN  = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic trig_s
);
  localparam int LEN = STAGES + ALIGN;

  logic [LEN-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[LEN-2:0], trig};
  end

  assign trig_s = chain[LEN-1];
endmodule

// File: rtl/sample_formatter.sv
module sample_formatter #(
  parameter int SMP_W      = sfmt_pkg::SMP_W,
  parameter int PIPE_DEPTH = sfmt_pkg::PIPE_DEPTH,
  parameter int SYNC_DEPTH = sfmt_pkg::SYNC_DEPTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [SMP_W-1:0] in_sample,
  input  logic             in_oor,
  input  logic             cfg_twos,
  input  logic             cfg_stamp,
  input  logic             trig_async,
  output logic             out_valid,
  output logic [SMP_W-1:0] out_sample,
  output logic             out_oor
);
  // one register stage is the output register; the rest form the delay line
  localparam int DLY_DEPTH = PIPE_DEPTH - 1;
  localparam int TRIG_PAD  = DLY_DEPTH - SYNC_DEPTH;
  localparam int BEAT_W    = SMP_W + 3;

  logic [SMP_W-1:0]  coded;
  logic [BEAT_W-1:0] beat_in, beat_dly;
  logic              trig_s;
  logic              d_vld, d_stamp, d_oor;
  logic [SMP_W-1:0]  d_word;

  sfmt_coder #(.W(SMP_W)) i_coder (
    .coding (cfg_twos),
    .raw    (in_sample),
    .coded  (coded)
  );

  assign beat_in = {in_valid, cfg_stamp, in_oor, coded};

  sfmt_delay #(.W(BEAT_W), .DEPTH(DLY_DEPTH)) i_delay (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (beat_in),
    .q     (beat_dly)
  );

  sfmt_trig_sync #(.STAGES(SYNC_DEPTH), .ALIGN(TRIG_PAD)) i_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig   (trig_async),
    .trig_s (trig_s)
  );

  assign {d_vld, d_stamp, d_oor, d_word} = beat_dly;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
      out_oor    <= 1'b0;
    end else begin
      out_valid <= d_vld;
      if (d_vld) begin
        out_sample <= d_stamp ? {d_word[SMP_W-1:1], trig_s} : d_word;
        out_oor    <= d_oor;
      end
    end
  end
endmodule

// File: rtl/sfmt_checker.sv
module sfmt_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [11:0] in_sample,
  input logic        in_oor,
  input logic        cfg_twos,
  input logic        cfg_stamp,
  input logic        trig_async,
  input logic        out_valid,
  input logic [11:0] out_sample,
  input logic        out_oor
);
  logic [1:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         warm <= 2'd0;
    else if (warm != 3) warm <= warm + 2'd1;
  end

  always @(posedge clk)
    if (!rst_n)
      AST_RESET_QUIET: assert (!out_valid && out_sample == '0 && !out_oor); // R1

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 3) |-> (out_valid == $past(in_valid, 3))); // R2

  AST_MID_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 3 && out_valid) |-> (out_sample[10:1] == $past(in_sample[10:1], 3))); // R3

  AST_MSB_CODING: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 3 && out_valid) |->
      (out_sample[11] == ($past(in_sample[11], 3) ^ $past(cfg_twos, 3)))); // R4

  AST_STAMP_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 3 && out_valid && $past(cfg_stamp, 3)) |->
      (out_sample[0] == $past(trig_async, 3))); // R5

  AST_PLAIN_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 3 && out_valid && !$past(cfg_stamp, 3)) |->
      (out_sample[0] == $past(in_sample[0], 3))); // R6

  AST_OOR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 3 && out_valid) |-> (out_oor == $past(in_oor, 3))); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (warm != 0 && !out_valid) |-> ($stable(out_sample) && $stable(out_oor))); // R9
endmodule

bind sample_formatter sfmt_checker i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_sample  (in_sample),
  .in_oor     (in_oor),
  .cfg_twos   (cfg_twos),
  .cfg_stamp  (cfg_stamp),
  .trig_async (trig_async),
  .out_valid  (out_valid),
  .out_sample (out_sample),
  .out_oor    (out_oor)
);

// File: tb/test_sample_formatter.sv
`timescale 1ns/1ps
module test_sample_formatter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [11:0] in_sample = '0;
  logic        in_oor = 1'b0;
  logic        cfg_twos = 1'b0;
  logic        cfg_stamp = 1'b0;
  logic        trig_async = 1'b0;
  logic        out_valid;
  logic [11:0] out_sample;
  logic        out_oor;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sample_formatter i_sample_formatter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .in_oor(in_oor), .cfg_twos(cfg_twos), .cfg_stamp(cfg_stamp),
    .trig_async(trig_async), .out_valid(out_valid), .out_sample(out_sample),
    .out_oor(out_oor)
  );

  // entry: {valid, twos, stamp, trig, oor, sample[11:0]}
  localparam int NV = 16;
  localparam logic [16:0] VEC [NV] = '{
    {5'b10000, 12'h000},  // R3 plain
    {5'b10010, 12'hFFF},  // R6 trigger ignored
    {5'b11000, 12'h800},  // R4
    {5'b11000, 12'h7FF},  // R4
    {5'b10110, 12'hA54},  // R5
    {5'b10100, 12'hA55},  // R5
    {5'b11110, 12'h123},  // R5 + R4
    {5'b10001, 12'hFFF},  // R7
    {5'b01111, 12'h3C3},  // R9 idle
    {5'b00000, 12'h000},  // R9 idle
    {5'b11101, 12'h801},  // R7 + R5
    {5'b10110, 12'h000},  // R5
    {5'b10010, 12'h554},  // R6
    {5'b11010, 12'h554},  // R8 switch per sample
    {5'b10000, 12'hABC},  // R8 switch back
    {5'b11111, 12'hABC}   // R4 R5 R7
  };

  function automatic logic [11:0] fmt(logic twos, logic stamp, logic trig, logic [11:0] s);
    return {s[11] ^ twos, s[10:1], stamp ? trig : s[0]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(logic [16:0] v);
    {in_valid, cfg_twos, cfg_stamp, trig_async, in_oor, in_sample} = v;
  endtask

  initial begin
    logic [11:0] held_s;
    logic        held_o;
    // reset state
    #1;
    check("R1 valid in reset", out_valid, 0);
    check("R1 sample in reset", out_sample, 0);
    check("R1 oor in reset", out_oor, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    held_s = '0;
    held_o = 1'b0;

    // table walk: check entry i-3 then drive entry i
    for (int i = 0; i < NV + 3; i++) begin
      @(negedge clk);
      if (i >= 3) begin
        logic [16:0] e;
        e = VEC[i-3];
        check("R2 strobe", out_valid, e[16]);
        if (e[16]) begin
          held_s = fmt(e[15], e[14], e[13], e[11:0]);
          held_o = e[12];
          check("R3 R4 R5 R6 R8 word", out_sample, held_s);
          check("R7 oor", out_oor, held_o);
        end else begin
          check("R9 hold word", out_sample, held_s);
          check("R9 hold oor", out_oor, held_o);
        end
      end
      if (i < NV) drive(VEC[i]);
      else        drive('0);
    end

    // R2 single beat latency
    @(negedge clk); drive({5'b10000, 12'h5A5});
    @(negedge clk); drive('0);
    check("R2 edge1", out_valid, 0);
    @(negedge clk); check("R2 edge2", out_valid, 0);
    @(negedge clk); check("R2 edge3", out_valid, 1);
    check("R2 word", out_sample, 12'h5A5);
    @(negedge clk); check("R2 single beat", out_valid, 0);

    // R5 one-cycle trigger pulse lands on one word only
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (k >= 3) check("R5 pulse alignment", out_sample[0], (k == 5) ? 1 : 0);
      drive({1'b1, 1'b0, 1'b1, (k == 2), 1'b0, 12'h000});
    end

    // R1 reset mid-stream clears outputs at once
    @(negedge clk); drive({5'b10001, 12'hFFF});
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #0.5;
    check("R1 async valid", out_valid, 0);
    check("R1 async word", out_sample, 0);
    check("R1 async oor", out_oor, 0);
    drive('0);
    @(negedge clk); rst_n = 1'b1;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule